// File: doc/BRIEF.md
# Latching Power-Event Interrupt Bank

This block watches eight level-sensitive event lines, such as power-down indications, and records each qualifying event in a sticky flag. The flag flops take their set from the event line itself and never from the bus clock. An event that occurs while the bus clock is stopped is therefore still recorded, and software finds it once the clock runs again.

Software sees the flags through a small register port. Per line it can enable capture, choose the active level, and choose between sticky capture and a live view of the level. It can read the raw and the enabled (masked) status and clear flags by writing ones. The OR of the masked status drives a single registered interrupt output. The flags reach the bus domain through a two-flop synchronizer. A clear write is held for a few bus cycles so that it reliably resets the flag flop.

Top module: `pwr_evt_latch`

## Requirements
- R1: After reset, the enable, polarity, mode, raw and masked registers all read 0 and `irq` is low.
- R2: The enable (offset 0x00), polarity (0x10) and mode (0x14) registers are read/write. Bit i of each register controls line i.
- R3: With polarity bit 0, a line is active while its input is high. An enabled active line sets raw status bit i, which is read at offset 0x04.
- R4: With polarity bit 1, a line is active while its input is low.
- R5: When mode bit i is 0, the flag stays set after the input returns inactive. An active pulse on an enabled line is captured even while the bus clock is stopped.
- R6: Writing 1 to bit i at offset 0x0C clears the flag of line i if the line is inactive. Bits written as 0 leave their flags unchanged.
- R7: If a line is still active when its clear is written, its flag stays set. The flag remains set after the line later goes inactive.
- R8: The masked status at offset 0x08 equals raw AND enable. A line whose enable bit is 0 does not set its flag.
- R9: When mode bit i is 1, raw bit i follows the synchronized qualified level and does not hold a past event.
- R10: `irq` is a registered output. It is high when any masked status bit is 1 and goes low once all masked bits are 0.
- R11: The clear register and any unused offset read as 0. Writes to the raw and masked offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, may be stopped |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is valid the next cycle |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 8 | Write data, one bit per line |
| rdata | output | 8 | Registered read data |
| evt_in | input | 8 | Event input lines |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
The bench builds the block with its default values: eight lines, two synchronizer stages and a four-cycle clear stretch. With these values, every line, the full settle latency and the clear-hold window can be reached in short directed runs. The bench stops the bus clock and pulses a line while the clock is stopped, which exercises capture without the clock. It writes a clear while a line is still active to exercise the re-set rule. It toggles enable and mode around a held flag to separate the raw status from the masked status and the sticky view from the live view.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_EN   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_RAW  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_MSK  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_POL  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_MODE = 5'h14;
endpackage

// File: rtl/pwr_evt_sync.sv
module pwr_evt_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_evt_capture.sv
module pwr_evt_capture #(
  parameter int LINES = 8
) (
  input  logic [LINES-1:0] line_in,
  input  logic [LINES-1:0] en,
  input  logic [LINES-1:0] pol,
  input  logic [LINES-1:0] clr,
  output logic [LINES-1:0] flag,
  output logic [LINES-1:0] level
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic qual;
    logic wipe;
    logic held;
    assign qual = (line_in[i] ^ pol[i]) & en[i];
    assign wipe = clr[i] & ~qual;

    always_ff @(posedge qual or posedge wipe) begin
      if (clr[i] && !qual) held <= 1'b0;
      else                 held <= 1'b1;
    end

    assign flag[i]  = held;
    assign level[i] = qual;
  end
endmodule

// File: rtl/pwr_evt_regs.sv
module pwr_evt_regs
  import pwr_evt_pkg::*;
#(
  parameter int LINES       = 8,
  parameter int CLR_STRETCH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINES-1:0]  wdata,
  input  logic [LINES-1:0]  flag_s,
  input  logic [LINES-1:0]  level_s,
  output logic [LINES-1:0]  rdata,
  output logic              irq,
  output logic [LINES-1:0]  en_q,
  output logic [LINES-1:0]  pol_q,
  output logic [LINES-1:0]  clr_q
);
  localparam int CW = $clog2(CLR_STRETCH + 1);

  logic [LINES-1:0] mode_q;
  logic [CW-1:0]    hold_cnt;
  logic [LINES-1:0] raw_v;
  logic [LINES-1:0] msk_v;

  assign raw_v = (mode_q & level_s) | (~mode_q & flag_s);
  assign msk_v = raw_v & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_EN:   en_q   <= wdata;
        OFS_POL:  pol_q  <= wdata;
        OFS_MODE: mode_q <= wdata;
        default: ;
      endcase
    end
  end

  // clear pulse held for CLR_STRETCH cycles; reset wipes every flag the same way
  always_ff @(posedge clk) begin
    if (rst) begin
      clr_q    <= '1;
      hold_cnt <= CW'(CLR_STRETCH);
    end else if (wr_en && addr == OFS_CLR && wdata != '0) begin
      clr_q    <= clr_q | wdata;
      hold_cnt <= CW'(CLR_STRETCH);
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
      if (hold_cnt == CW'(1)) clr_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= |msk_v;
      if (rd_en) begin
        case (addr)
          OFS_EN:   rdata <= en_q;
          OFS_RAW:  rdata <= raw_v;
          OFS_MSK:  rdata <= msk_v;
          OFS_POL:  rdata <= pol_q;
          OFS_MODE: rdata <= mode_q;
          default:  rdata <= '0;
        endcase
      end else begin
        rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/pwr_evt_latch.sv
module pwr_evt_latch
  import pwr_evt_pkg::*;
#(
  parameter int LINES       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CLR_STRETCH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINES-1:0]  wdata,
  output logic [LINES-1:0]  rdata,
  input  logic [LINES-1:0]  evt_in,
  output logic              irq
);
  logic [LINES-1:0] en_w, pol_w, clr_w;
  logic [LINES-1:0] flag_w, level_w;
  logic [LINES-1:0] flag_s, level_s;

  pwr_evt_capture #(.LINES(LINES)) u_cap (
    .line_in(evt_in), .en(en_w), .pol(pol_w), .clr(clr_w),
    .flag(flag_w), .level(level_w)
  );

  pwr_evt_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync_flag (
    .clk(clk), .rst(rst), .d(flag_w), .q(flag_s)
  );

  pwr_evt_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync_lvl (
    .clk(clk), .rst(rst), .d(level_w), .q(level_s)
  );

  pwr_evt_regs #(.LINES(LINES), .CLR_STRETCH(CLR_STRETCH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .flag_s(flag_s), .level_s(level_s), .rdata(rdata),
    .irq(irq), .en_q(en_w), .pol_q(pol_w), .clr_q(clr_w)
  );
endmodule

// File: rtl/pwr_evt_latch_chk.sv
module pwr_evt_latch_chk
  import pwr_evt_pkg::*;
#(
  parameter int LINES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [LINES-1:0]  rdata,
  input logic              irq,
  input logic [LINES-1:0]  en_q,
  input logic [LINES-1:0]  clr_q
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq && en_q == '0 && rdata == '0));

  assert_disabled_no_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq);

  assert_clear_stretched_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(|clr_q) |=> (|clr_q));

  assert_clear_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_CLR) |=> (rdata == '0));
endmodule

bind pwr_evt_latch pwr_evt_latch_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .irq(irq), .en_q(en_w), .clr_q(clr_w)
);

// File: tb/pwr_evt_latch_bench.sv
`timescale 1ns/1ps
module pwr_evt_latch_bench;
  import pwr_evt_pkg::*;

  logic             clk = 1'b0;
  logic             clk_run = 1'b1;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic             rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]       wdata = '0;
  logic [7:0]       rdata;
  logic [7:0]       evt_in = '0;
  logic             irq;
  int               n_chk = 0;
  int               n_bad = 0;

  pwr_evt_latch u_pwr_evt_latch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .irq(irq)
  );

  initial forever begin
    #2.5;
    if (clk_run) clk = ~clk;
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_read(a, v);
    check(tag, v, exp);
  endtask

  task automatic clear_and_settle(input logic [7:0] bits);
    bus_write(OFS_CLR, bits);
    wait_cyc(8);
  endtask

  task automatic t_reset;
    expect_reg("R1 enable", OFS_EN, 8'h00);
    expect_reg("R1 polarity", OFS_POL, 8'h00);
    expect_reg("R1 mode", OFS_MODE, 8'h00);
    expect_reg("R1 raw", OFS_RAW, 8'h00);
    expect_reg("R1 masked", OFS_MSK, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_regs;
    bus_write(OFS_POL, 8'h3C);
    bus_write(OFS_MODE, 8'h81);
    expect_reg("R2 polarity", OFS_POL, 8'h3C);
    expect_reg("R2 mode", OFS_MODE, 8'h81);
    bus_write(OFS_POL, 8'h00);
    bus_write(OFS_MODE, 8'h00);
    bus_write(OFS_EN, 8'hA5);
    expect_reg("R2 enable", OFS_EN, 8'hA5);
    bus_write(OFS_EN, 8'h00);
    bus_write(OFS_RAW, 8'hFF);
    bus_write(OFS_MSK, 8'hFF);
    wait_cyc(4);
    expect_reg("R11 raw write ignored", OFS_RAW, 8'h00);
    expect_reg("R11 clear reads 0", OFS_CLR, 8'h00);
    expect_reg("R11 unused offset", 5'h18, 8'h00);
  endtask

  task automatic t_high;
    bus_write(OFS_EN, 8'h01);
    evt_in[0] = 1'b1;
    wait_cyc(4);
    expect_reg("R3 raw active-high", OFS_RAW, 8'h01);
    expect_reg("R8 masked", OFS_MSK, 8'h01);
    check("R10 irq high", {7'd0, irq}, 8'h01);
    evt_in[0] = 1'b0;
    wait_cyc(4);
    expect_reg("R5 sticky", OFS_RAW, 8'h01);
    clear_and_settle(8'h01);
    expect_reg("R6 cleared", OFS_RAW, 8'h00);
    check("R10 irq low", {7'd0, irq}, 8'h00);
    bus_write(OFS_EN, 8'h00);
  endtask

  task automatic t_low;
    evt_in[1] = 1'b1;
    bus_write(OFS_POL, 8'h02);
    bus_write(OFS_EN, 8'h02);
    wait_cyc(4);
    expect_reg("R4 idle high", OFS_RAW, 8'h00);
    evt_in[1] = 1'b0;
    wait_cyc(4);
    expect_reg("R4 active-low", OFS_RAW, 8'h02);
    evt_in[1] = 1'b1;
    clear_and_settle(8'h02);
    expect_reg("R4 cleared", OFS_RAW, 8'h00);
    bus_write(OFS_EN, 8'h00);
    bus_write(OFS_POL, 8'h00);
    evt_in[1] = 1'b0;
  endtask

  task automatic t_clockless;
    bus_write(OFS_EN, 8'h20);
    @(negedge clk);
    clk_run = 1'b0;
    #20;
    evt_in[5] = 1'b1;
    #3;
    evt_in[5] = 1'b0;
    #20;
    clk_run = 1'b1;
    wait_cyc(4);
    expect_reg("R5 captured with clock stopped", OFS_RAW, 8'h20);
    clear_and_settle(8'h20);
    expect_reg("R5 clear after clockless", OFS_RAW, 8'h00);
    bus_write(OFS_EN, 8'h00);
  endtask

  task automatic t_reassert;
    bus_write(OFS_EN, 8'h08);
    evt_in[3] = 1'b1;
    wait_cyc(4);
    clear_and_settle(8'h08);
    expect_reg("R7 still active after clear", OFS_RAW, 8'h08);
    evt_in[3] = 1'b0;
    wait_cyc(4);
    expect_reg("R7 held after release", OFS_RAW, 8'h08);
    clear_and_settle(8'h08);
    expect_reg("R7 final clear", OFS_RAW, 8'h00);
    bus_write(OFS_EN, 8'h00);
  endtask

  task automatic t_partial;
    bus_write(OFS_EN, 8'h30);
    evt_in[4] = 1'b1; evt_in[5] = 1'b1;
    wait_cyc(2);
    evt_in[4] = 1'b0; evt_in[5] = 1'b0;
    wait_cyc(4);
    expect_reg("R6 both set", OFS_RAW, 8'h30);
    clear_and_settle(8'h10);
    expect_reg("R6 partial clear", OFS_RAW, 8'h20);
    clear_and_settle(8'h20);
    bus_write(OFS_EN, 8'h00);
  endtask

  task automatic t_mask;
    bus_write(OFS_EN, 8'h04);
    evt_in[2] = 1'b1;
    wait_cyc(2);
    evt_in[2] = 1'b0;
    wait_cyc(4);
    bus_write(OFS_EN, 8'h00);
    wait_cyc(2);
    expect_reg("R8 raw kept when disabled", OFS_RAW, 8'h04);
    expect_reg("R8 masked off", OFS_MSK, 8'h00);
    check("R8 irq masked", {7'd0, irq}, 8'h00);
    bus_write(OFS_EN, 8'h04);
    wait_cyc(2);
    expect_reg("R8 masked on", OFS_MSK, 8'h04);
    check("R10 irq after enable", {7'd0, irq}, 8'h01);
    clear_and_settle(8'h04);
    bus_write(OFS_EN, 8'h00);
    evt_in[6] = 1'b1;
    wait_cyc(4);
    expect_reg("R8 disabled line ignored", OFS_RAW, 8'h00);
    check("R8 disabled irq", {7'd0, irq}, 8'h00);
    evt_in[6] = 1'b0;
  endtask

  task automatic t_mode;
    bus_write(OFS_MODE, 8'h80);
    bus_write(OFS_EN, 8'h80);
    evt_in[7] = 1'b1;
    wait_cyc(4);
    expect_reg("R9 live level high", OFS_RAW, 8'h80);
    check("R9 irq live", {7'd0, irq}, 8'h01);
    evt_in[7] = 1'b0;
    wait_cyc(4);
    expect_reg("R9 live level low", OFS_RAW, 8'h00);
    check("R9 irq follows", {7'd0, irq}, 8'h00);
    bus_write(OFS_MODE, 8'h00);
    clear_and_settle(8'h80);
    bus_write(OFS_EN, 8'h00);
  endtask

  initial begin
    #500_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(8);
    t_reset();
    t_regs();
    t_high();
    t_low();
    t_clockless();
    t_reassert();
    t_partial();
    t_mask();
    t_mode();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule